// File: doc/BRIEF.md
# Reset and Boot-Mode Controller

This block merges an active-low external reset pin and a watchdog reset request into one core and peripheral reset, all on the master clock. The external pin pulls the core reset down at once, with no clock edge needed. Release passes through a synchroniser, so the core reset always rises on a clock edge. A watchdog request makes a reset of fixed length. It resets the same logic, but it leaves the sampled configuration as it was.

When an external reset is released, the block captures a boot-mode selection and decides whether the chip runs in output-disable (tri-state) mode. Tri-state mode is chosen only when the tri-state request pin was low for a full window of clock edges just before release. After every core reset release, the processor fetch enable is held back for a fixed number of cycles. A clock-out enable is low while the external reset is in force and high afterwards. Every output is a plain level with no handshake, because nothing streams through this block.

Top module: `rstboot_ctrl`

## Requirements
- R1: A low level on `ext_rst_n` drives `core_rst_n`, `clkout_en` and `fetch_en` low at once, without waiting for a clock edge.
- R2: After `ext_rst_n` goes high, `core_rst_n` and `clkout_en` rise on the second rising clock edge (SYNC_STAGES = 2) at which the pin is seen high.
- R3: `fetch_en` is low while `core_rst_n` is low. It rises after exactly FETCH_DELAY (80) rising edges following the edge on which `core_rst_n` rose, and then stays high.
- R4: `out_disable` is 1 after release only if `tri_req_n` was 0 at each of the last TRI_WINDOW (10) rising edges at which `ext_rst_n` was low. Otherwise it is 0, and this includes resets shorter than the window.
- R5: `boot_mode` takes the value of `boot_sel` at the edge on which the core reset releases after an external reset. It keeps that value until the next external reset.
- R6: A `wdog_req` sampled high at a rising edge while the core is running holds `core_rst_n` low for exactly WDOG_LEN (4) cycles, starting after that edge. Requests that arrive during this pulse are ignored.
- R7: A watchdog reset leaves `boot_mode`, `out_disable` and `clkout_en` unchanged.
- R8: While `ext_rst_n` is low, `wdog_req` has no effect, so the release timing is the one given in R2.
- R9: `clkout_en` stays high through a watchdog reset. It is low only while the external reset is asserted or still being synchronised.
- R10: A watchdog reset clears `fetch_en` one edge after it starts. After the watchdog reset ends, FETCH_DELAY edges must pass again before `fetch_en` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| ext_rst_n | input | 1 | Raw external reset pin, active low, asynchronous |
| wdog_req | input | 1 | Watchdog reset request, synchronous to clk |
| boot_sel | input | BOOT_W | Boot-mode pins |
| tri_req_n | input | 1 | Tri-state request pin, active low |
| core_rst_n | output | 1 | Core and peripheral reset, active low |
| fetch_en | output | 1 | Processor instruction fetch permitted |
| boot_mode | output | BOOT_W | Latched boot mode |
| out_disable | output | 1 | Global output driver disable (tri-state mode) |
| clkout_en | output | 1 | Clock output enable |

## Verification
A watchdog request and an external reset can be active in the same cycle. The bench provokes this by holding `wdog_req` high for the whole external reset, up to the moment the pin is released. It then judges the result by checking that the release edge matches the plain external case and that `core_rst_n` stays high afterwards. The second overlap is a new watchdog request that arrives while a watchdog pulse is already running. This is judged by checking that the low time is still exactly four cycles.

// File: rtl/rbc_pkg.sv
package rbc_pkg;
  // Width needed to hold a count from 0 to n inclusive.
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/rbc_reset_sync.sv
module rbc_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic pin_n,
  output logic rst_n_sync,
  output logic rel_next
);
  logic [STAGES-1:0] q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge pin_n)
          if (!pin_n) q[g] <= 1'b0;
          else        q[g] <= 1'b1;
      end else begin : g_next
        always_ff @(posedge clk or negedge pin_n)
          if (!pin_n) q[g] <= 1'b0;
          else        q[g] <= q[g-1];
      end
    end
  endgenerate

  assign rst_n_sync = q[STAGES-1];
  // High in the cycle before the synchronised release edge.
  assign rel_next   = q[STAGES-2] & ~q[STAGES-1];
endmodule

// File: rtl/rbc_wdog_stretch.sv
module rbc_wdog_stretch #(
  parameter int unsigned LEN = 4
) (
  input  logic clk,
  input  logic arst_n,
  input  logic req,
  output logic active
);
  import rbc_pkg::*;
  localparam int unsigned CW = cnt_w(LEN);
  localparam int unsigned RW = cnt_w(LEN + 1);

  logic [CW-1:0] left;

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n)                 left <= '0;
    else if (left != '0)         left <= left - 1'b1;
    else if (req)                left <= CW'(LEN);

  assign active = (left != '0);

  // Checker: length of each low pulse.
  logic [RW-1:0] run;
  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n)     run <= '0;
    else if (active) run <= run + 1'b1;
    else             run <= '0;

  assert_wd_len_R6: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(active) |-> (run == RW'(LEN)));
endmodule

// File: rtl/rbc_mode_latch.sv
module rbc_mode_latch #(
  parameter int unsigned BOOT_W = 2,
  parameter int unsigned WINDOW = 10
) (
  input  logic              clk,
  input  logic              pin_n,
  input  logic              run_n,
  input  logic              rel_next,
  input  logic [BOOT_W-1:0] boot_sel,
  input  logic              tri_req_n,
  output logic [BOOT_W-1:0] boot_mode,
  output logic              tri_sel
);
  import rbc_pkg::*;
  localparam int unsigned WW = cnt_w(WINDOW);

  // Count of consecutive low samples of the tri-state pin, saturating.
  logic [WW-1:0] low_run;

  always_ff @(posedge clk)
    if (!pin_n) begin
      if (tri_req_n)                  low_run <= '0;
      else if (low_run != WW'(WINDOW)) low_run <= low_run + 1'b1;
    end else if (run_n) begin
      low_run <= '0;
    end

  always_ff @(posedge clk or negedge pin_n)
    if (!pin_n) begin
      boot_mode <= '0;
      tri_sel   <= 1'b0;
    end else if (rel_next) begin
      boot_mode <= boot_sel;
      tri_sel   <= (low_run == WW'(WINDOW));
    end

  assert_tri_rise_R4: assert property (@(posedge clk) disable iff (!pin_n)
    $rose(tri_sel) |-> $past(rel_next));

  assert_mode_hold_R7: assert property (@(posedge clk) disable iff (!pin_n)
    !rel_next |=> ($stable(boot_mode) && $stable(tri_sel)));
endmodule

// File: rtl/rbc_fetch_gate.sv
module rbc_fetch_gate #(
  parameter int unsigned DELAY = 80
) (
  input  logic clk,
  input  logic arst_n,
  input  logic core_rst_n,
  output logic fetch_en
);
  import rbc_pkg::*;
  localparam int unsigned DW = cnt_w(DELAY);

  logic [DW-1:0] cnt;

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n)                   cnt <= '0;
    else if (!core_rst_n)          cnt <= '0;
    else if (cnt != DW'(DELAY))    cnt <= cnt + 1'b1;

  assign fetch_en = (cnt == DW'(DELAY));

  assert_fetch_hold_R3: assert property (@(posedge clk) disable iff (!arst_n)
    (fetch_en && core_rst_n) |=> fetch_en);

  assert_fetch_clear_R10: assert property (@(posedge clk) disable iff (!arst_n)
    !core_rst_n |=> !fetch_en);
endmodule

// File: rtl/rstboot_ctrl.sv
module rstboot_ctrl #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FETCH_DELAY = 80,
  parameter int unsigned TRI_WINDOW  = 10,
  parameter int unsigned WDOG_LEN    = 4,
  parameter int unsigned BOOT_W      = 2
) (
  input  logic              clk,
  input  logic              ext_rst_n,
  input  logic              wdog_req,
  input  logic [BOOT_W-1:0] boot_sel,
  input  logic              tri_req_n,
  output logic              core_rst_n,
  output logic              fetch_en,
  output logic [BOOT_W-1:0] boot_mode,
  output logic              out_disable,
  output logic              clkout_en
);
  logic ext_run_n;
  logic rel_next;
  logic wd_active;

  rbc_reset_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .pin_n(ext_rst_n), .rst_n_sync(ext_run_n), .rel_next(rel_next)
  );

  // External reset clears the stretcher, so it has priority.
  rbc_wdog_stretch #(.LEN(WDOG_LEN)) u_wdog (
    .clk(clk), .arst_n(ext_run_n), .req(wdog_req), .active(wd_active)
  );

  rbc_mode_latch #(.BOOT_W(BOOT_W), .WINDOW(TRI_WINDOW)) u_mode (
    .clk(clk), .pin_n(ext_rst_n), .run_n(ext_run_n), .rel_next(rel_next),
    .boot_sel(boot_sel), .tri_req_n(tri_req_n),
    .boot_mode(boot_mode), .tri_sel(out_disable)
  );

  assign core_rst_n = ext_run_n & ~wd_active;
  assign clkout_en  = ext_run_n;

  rbc_fetch_gate #(.DELAY(FETCH_DELAY)) u_fetch (
    .clk(clk), .arst_n(ext_run_n), .core_rst_n(core_rst_n), .fetch_en(fetch_en)
  );

  assert_clkout_wd_R9: assert property (@(posedge clk) disable iff (!ext_run_n)
    wd_active |-> clkout_en);
endmodule

// File: tb/rstboot_ctrl_bench.sv
`timescale 1ns/1ps
module rstboot_ctrl_bench;
  logic       clk = 1'b0;
  logic       ext_rst_n = 1'b0;
  logic       wdog_req = 1'b0;
  logic [1:0] boot_sel = 2'b00;
  logic       tri_req_n = 1'b1;
  logic       core_rst_n, fetch_en, out_disable, clkout_en;
  logic [1:0] boot_mode;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  rstboot_ctrl u_rstboot_ctrl (
    .clk(clk), .ext_rst_n(ext_rst_n), .wdog_req(wdog_req), .boot_sel(boot_sel),
    .tri_req_n(tri_req_n), .core_rst_n(core_rst_n), .fetch_en(fetch_en),
    .boot_mode(boot_mode), .out_disable(out_disable), .clkout_en(clkout_en)
  );

  // Each row: reset length, trailing tri-low edges, boot value, expected tri flag.
  localparam int VEC [6][4] = '{
    '{12, 12, 1, 1}, '{12, 9, 2, 0}, '{9, 9, 3, 0},
    '{10, 10, 0, 1}, '{15, 10, 2, 1}, '{20, 0, 1, 0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic negs(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Starts at a negedge just after core_rst_n rose.
  task automatic chk_fetch(input string req);
    negs(79);
    chk(req, fetch_en, 0);
    negs(1);
    chk(req, fetch_en, 1);
  endtask

  task automatic ext_cycle(input int len, input int tail, input int boot,
                           input int exp_tri, input bit wd_on);
    @(negedge clk);
    ext_rst_n = 1'b0;
    boot_sel  = 2'(boot);
    wdog_req  = wd_on;
    for (int i = 0; i < len; i++) begin
      tri_req_n = (i >= len - tail) ? 1'b0 : 1'b1;
      @(negedge clk);
    end
    ext_rst_n = 1'b1;
    tri_req_n = 1'b1;
    wdog_req  = 1'b0;
    negs(1);
    chk("R2", core_rst_n, 0);
    chk("R9", clkout_en, 0);
    negs(1);
    chk("R2", core_rst_n, 1);
    chk("R9", clkout_en, 1);
    chk("R5", boot_mode, boot);
    chk("R4", out_disable, exp_tri);
    boot_sel = ~boot_sel;
    if (wd_on) begin
      negs(1);
      chk("R8", core_rst_n, 1);
      negs(4);
      chk("R8", core_rst_n, 1);
      negs(1);
      chk("R5", boot_mode, boot);
      return;
    end
    chk_fetch("R3");
    chk("R5", boot_mode, boot);
  endtask

  initial begin
    negs(3);
    chk("R1", core_rst_n, 0);
    chk("R1", fetch_en, 0);

    for (int v = 0; v < 6; v++)
      ext_cycle(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], 1'b0);

    // R1: assertion without a clock edge
    #3;
    ext_rst_n = 1'b0;
    #1;
    chk("R1", core_rst_n, 0);
    chk("R1", clkout_en, 0);
    chk("R1", fetch_en, 0);
    ext_cycle(11, 11, 2, 1, 1'b0);

    // R6, R7, R9, R10: watchdog pulse with a repeated request
    @(negedge clk);
    wdog_req = 1'b1;
    negs(1);
    chk("R6", core_rst_n, 0);
    negs(1);
    wdog_req = 1'b0;
    chk("R6", core_rst_n, 0);
    chk("R10", fetch_en, 0);
    chk("R9", clkout_en, 1);
    negs(1);
    chk("R6", core_rst_n, 0);
    negs(1);
    chk("R6", core_rst_n, 0);
    negs(1);
    chk("R6", core_rst_n, 1);
    chk("R7", boot_mode, 2);
    chk("R7", out_disable, 1);
    chk("R9", clkout_en, 1);
    chk_fetch("R10");

    // R8: watchdog request overlapping an external reset
    ext_cycle(12, 0, 3, 0, 1'b1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule